// File: doc/BRIEF.md
# Byte Replicate and Lane Store Unit

This unit lets a 32-bit processor write a single byte to a word-wide memory at any byte address. Each byte lane of the memory word has its own write enable. The unit does not shift the byte into position. It works in two steps.

First, a fill operation copies the low byte of the source operand into every byte lane of one fixed internal register, called the lane register. Second, a store operation sends the whole lane register to the memory write port. It raises the byte enable only for the lane that the low two address bits pick. The byte therefore already sits in the right lane, whatever the alignment of the address.

Operations arrive one per cycle as a valid flag plus a one-bit kind select. A store reaches the memory port one clock after it is accepted. Its write strobe stays high for exactly that one cycle.

Top module: `byte_lane_store`

## Requirements
- R1: After reset, memWrEn is 0 and memByteEn is 0, and the lane register holds zero. A store issued before any fill therefore writes data 0x00000000.
- R2: A fill (opValid=1, opSel=0) loads the lane register with bits 7..0 of srcData repeated in all four lanes. For example, 0x54 gives 0x54545454.
- R3: A fill causes no memory write: memWrEn is 0 in the cycle after the fill is accepted.
- R4: A store (opValid=1, opSel=1) drives memWrEn high in the cycle after it is accepted, for that one cycle only. Without a further store, memWrEn is 0 again the next cycle.
- R5: During a write, memByteEn is one-hot, with bit n set when byteAddr[1:0] equals n. Lane n is memWrData bits 8n+7..8n, and lane 0 is the lowest byte address. The three other bytes of the memory word are therefore left unchanged. For example, address 0x1203 enables only lane 3 (4'b1000).
- R6: During a write, memWordAddr equals byteAddr[31:2] of the accepted store. For example, 0x1203 gives 0x480.
- R7: During a write, memWrData carries the whole lane register as it stood when the store was accepted. The srcData value presented with the store has no effect on it.
- R8: A fill ignores srcData[31:8]: only the low byte reaches the lane register.
- R9: While memWrEn is 0, memByteEn is 4'b0000.
- R10: A cycle with opValid=0 changes nothing. The lane register keeps its value, and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 1 | Operation kind: 0 = fill, 1 = byte store |
| srcData | input | 32 | Source operand for fill; low byte used |
| byteAddr | input | 32 | Byte address for store |
| memWrEn | output | 1 | Memory write strobe |
| memWordAddr | output | 30 | Memory word address |
| memWrData | output | 32 | Memory write data (replicated lane register) |
| memByteEn | output | 4 | Per-lane write enable |

## Verification
On every cycle, the assertions check the following:
- A write always follows a store and never follows a fill.
- The enable is one-hot during a write and zero otherwise.
- The enabled lane and the word address match the previous cycle's address.
- The write data holds one byte value in all four lanes.

Only the bench's scenarios can show the rest, because it depends on history across several cycles:
- The data carries the byte from the most recent fill, and not the one presented with the store.
- The upper source bits are really ignored.
- Idle cycles preserve the lane register.
- Applying the enable to a preloaded memory word leaves the neighbouring bytes intact.

// File: rtl/bls_pkg.sv
package bls_pkg;
  typedef enum logic {
    OP_FILL  = 1'b0,
    OP_STORE = 1'b1
  } opKind_e;

  typedef struct packed {
    logic loadFill;
    logic issueStore;
  } laneStrobes_t;
endpackage

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic         opValid,
  input  logic         opSel,
  output laneStrobes_t strobes
);
  opKind_e opKind;

  always_comb begin
    opKind             = opKind_e'(opSel);
    strobes.loadFill   = 1'b0;
    strobes.issueStore = 1'b0;
    if (opValid) begin
      unique case (opKind)
        OP_FILL:  strobes.loadFill   = 1'b1;
        OP_STORE: strobes.issueStore = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bls_datapath.sv
module bls_datapath
  import bls_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  laneStrobes_t                               strobes,
  input  logic [DATA_W-1:0]                          srcData,
  input  logic [ADDR_W-1:0]                          byteAddr,
  output logic                                       memWrEn,
  output logic [ADDR_W-$clog2(DATA_W/LANE_W)-1:0]    memWordAddr,
  output logic [DATA_W-1:0]                          memWrData,
  output logic [DATA_W/LANE_W-1:0]                   memByteEn
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int SEL_W     = $clog2(NUM_LANES);
  localparam int WADDR_W   = ADDR_W - SEL_W;

  logic [DATA_W-1:0]    laneReg;
  logic [DATA_W-1:0]    replicated;
  logic [NUM_LANES-1:0] laneDecode;
  logic [SEL_W-1:0]     laneSel;

  assign laneSel = byteAddr[SEL_W-1:0];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign replicated[g*LANE_W +: LANE_W] = srcData[LANE_W-1:0];
    assign laneDecode[g] = (laneSel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneReg <= '0;
    end else if (strobes.loadFill) begin
      laneReg <= replicated;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn     <= 1'b0;
      memByteEn   <= '0;
      memWordAddr <= '0;
      memWrData   <= '0;
    end else begin
      memWrEn   <= strobes.issueStore;
      memByteEn <= strobes.issueStore ? laneDecode : '0;
      if (strobes.issueStore) begin
        memWordAddr <= byteAddr[ADDR_W-1:SEL_W];
        memWrData   <= laneReg;
      end
    end
  end

  logic [WADDR_W-1:0] unusedWidthTie;
  assign unusedWidthTie = memWordAddr;
endmodule

// File: rtl/byte_lane_store.sv
module byte_lane_store
  import bls_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32
) (
  input  logic                                     clk,
  input  logic                                     rstN,
  input  logic                                     opValid,
  input  logic                                     opSel,
  input  logic [DATA_W-1:0]                        srcData,
  input  logic [ADDR_W-1:0]                        byteAddr,
  output logic                                     memWrEn,
  output logic [ADDR_W-$clog2(DATA_W/LANE_W)-1:0]  memWordAddr,
  output logic [DATA_W-1:0]                        memWrData,
  output logic [DATA_W/LANE_W-1:0]                 memByteEn
);
  laneStrobes_t strobes;

  bls_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .strobes (strobes)
  );

  bls_datapath #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .srcData     (srcData),
    .byteAddr    (byteAddr),
    .memWrEn     (memWrEn),
    .memWordAddr (memWordAddr),
    .memWrData   (memWrData),
    .memByteEn   (memByteEn)
  );
endmodule

// File: rtl/bls_checker.sv
module bls_checker #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int ADDR_W = 32
) (
  input logic                                     clk,
  input logic                                     rstN,
  input logic                                     opValid,
  input logic                                     opSel,
  input logic [ADDR_W-1:0]                        byteAddr,
  input logic                                     memWrEn,
  input logic [ADDR_W-$clog2(DATA_W/LANE_W)-1:0]  memWordAddr,
  input logic [DATA_W-1:0]                        memWrData,
  input logic [DATA_W/LANE_W-1:0]                 memByteEn
);
  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int SEL_W     = $clog2(NUM_LANES);

  p_fill_nowrite_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSel) |=> !memWrEn);

  p_store_writes_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel) |=> memWrEn);

  p_write_has_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(opValid && opSel));

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($countones(memByteEn) == 1));

  p_lane_pick_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel) |=>
      (memByteEn == (NUM_LANES'(1) << $past(byteAddr[SEL_W-1:0]))));

  p_word_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel) |=> (memWordAddr == $past(byteAddr[ADDR_W-1:SEL_W])));

  p_replicated_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrData == {NUM_LANES{memWrData[LANE_W-1:0]}}));

  p_idle_enable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEn |-> (memByteEn == '0));
endmodule

bind byte_lane_store bls_checker #(
  .DATA_W (DATA_W),
  .LANE_W (LANE_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opValid     (opValid),
  .opSel       (opSel),
  .byteAddr    (byteAddr),
  .memWrEn     (memWrEn),
  .memWordAddr (memWordAddr),
  .memWrData   (memWrData),
  .memByteEn   (memByteEn)
);

// File: tb/tb_byte_lane_store.sv
module tb_byte_lane_store;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opSel = 1'b0;
  logic [31:0] srcData = '0;
  logic [31:0] byteAddr = '0;
  logic        memWrEn;
  logic [29:0] memWordAddr;
  logic [31:0] memWrData;
  logic [3:0]  memByteEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  byte_lane_store dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel),
    .srcData(srcData), .byteAddr(byteAddr), .memWrEn(memWrEn),
    .memWordAddr(memWordAddr), .memWrData(memWrData), .memByteEn(memByteEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  logic [31:0] refLane = '0;
  logic        expWrEn = 1'b0;
  logic [3:0]  expBe = '0;
  logic [29:0] expAddr = '0;
  logic [31:0] expData = '0;
  logic        lastWasFill = 1'b0;
  logic [31:0] mem [int];

  always @(posedge clk) begin
    if (!rstN) begin
      refLane <= '0; expWrEn <= 1'b0; expBe <= '0; lastWasFill <= 1'b0;
    end else begin
      expWrEn     <= opValid && opSel;
      expBe       <= (opValid && opSel) ? (4'b0001 << byteAddr[1:0]) : 4'b0000;
      lastWasFill <= opValid && !opSel;
      if (opValid && !opSel) refLane <= {4{srcData[7:0]}};
      if (opValid && opSel) begin
        expAddr <= byteAddr[31:2];
        expData <= refLane;
      end
    end
  end

  // Compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      check(lastWasFill ? "R3" : "R4", {31'b0, memWrEn}, {31'b0, expWrEn});
      check(expWrEn ? "R5" : "R9", {28'b0, memByteEn}, {28'b0, expBe});
      if (expWrEn) begin
        check("R6", {2'b0, memWordAddr}, {2'b0, expAddr});
        check("R7", memWrData, expData);
      end
      if (memWrEn) begin
        logic [31:0] w;
        w = mem.exists(int'(memWordAddr)) ? mem[int'(memWordAddr)] : 32'h0;
        for (int i = 0; i < 4; i++)
          if (memByteEn[i]) w[i*8 +: 8] = memWrData[i*8 +: 8];
        mem[int'(memWordAddr)] = w;
      end
    end
  end

  task automatic drive(input logic v, input logic s, input logic [31:0] d, input logic [31:0] a);
    @(negedge clk);
    opValid = v; opSel = s; srcData = d; byteAddr = a;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'b0, memWrEn}, 32'h0);
    check("R1", {28'b0, memByteEn}, 32'h0);
    rstN = 1'b1;

    // R1: store before any fill writes zero data
    drive(1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_0100);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R1", memWrData, 32'h0);

    // R2/R5: fill 0x54, store to 0x1203 over a preloaded word
    mem[int'(30'h480)] = 32'h0053_4946;
    drive(1'b1, 1'b0, 32'h0000_0054, 32'h0);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R3", {31'b0, memWrEn}, 32'h0);
    drive(1'b1, 1'b1, 32'h0, 32'h0000_1203);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R2", memWrData, 32'h5454_5454);
    check("R5", {28'b0, memByteEn}, 32'h8);
    check("R6", {2'b0, memWordAddr}, 32'h480);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R4", {31'b0, memWrEn}, 32'h0);
    check("R5", mem[int'(30'h480)], 32'h5453_4946);

    // R8: upper source bits ignored
    drive(1'b1, 1'b0, 32'hABCD_EF3C, 32'h0);
    drive(1'b1, 1'b1, 32'h1234_5678, 32'h0000_2001);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R8", memWrData, 32'h3C3C_3C3C);
    check("R5", {28'b0, memByteEn}, 32'h2);

    // R10: idle cycles keep the lane register
    drive(1'b0, 1'b0, 32'h0000_0099, 32'h0000_0002);
    drive(1'b0, 1'b1, 32'h0000_0077, 32'h0000_0002);
    drive(1'b1, 1'b1, 32'h0000_0011, 32'h0000_3002);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R10", memWrData, 32'h3C3C_3C3C);
    check("R5", {28'b0, memByteEn}, 32'h4);

    // Back-to-back stores, every lane
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 32'h0, 32'h0000_4000 + i);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    check("R5", mem[int'(30'h1000)], 32'h3C3C_3C3C);

    // Random mix, compared each clock by the model
    for (int n = 0; n < 400; n++)
      drive(1'($urandom), 1'($urandom), $urandom, $urandom);
    drive(1'b0, 1'b0, 32'h0, 32'h0);
    drive(1'b0, 1'b0, 32'h0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule